// File: doc/BRIEF.md
# Endian-Configurable Memory Access Port

This block connects a 32-bit processor core to a byte-addressed on-chip RAM. The core issues one request per cycle: a byte, 16-bit word or 32-bit long access, read or write. A static input chooses the byte lane order: little-endian or big-endian. Each address is checked against the configured memory size with a single mask test that depends on the access size. That one test rejects out-of-range addresses and misaligned addresses alike. A rejected access is reported as a bus error, writes nothing and returns zero.

Byte accesses that fall in a high I/O window skip the RAM and go to a small serial register set. This set has a transmit holding register, a receive register and a status byte. The serial side is exposed as plain valid/ready byte signals. Reads return their data one cycle after the request. Signed byte and word reads are sign-extended to 32 bits; unsigned ones are zero-extended.

Top module: `mem_port`

## Requirements
- R1: With memory size 2^ADDR_BITS bytes (ADDR_BITS from 3 to 24), the byte mask is size-1, the word mask clears bit 0 of it and the long mask clears bits 1:0. A request whose address has any bit set outside the mask for its size raises err_o in the cycle after the request, for one cycle.
- R2: An errored access writes nothing to the RAM. A read that errors still raises rvalid_o, with rdata_o equal to zero. The size code 3 is always an error. Size codes are 0 byte, 1 word, 2 long.
- R3: With big_endian_i low, the lowest address of a word or long holds its least significant byte.
- R4: With big_endian_i high, the lowest address of a word or long holds its most significant byte.
- R5: Byte accesses give the same result in both lane orders.
- R6: With signed_i high, byte and word reads are sign-extended to 32 bits. With signed_i low, they are zero-extended.
- R7: A read request raises rvalid_o, with its data, exactly one cycle later. A write request never raises rvalid_o.
- R8: A byte access with an address above 0x05000000 is an I/O access. It does not touch the RAM and is never an error. A byte read there of an address that is not a serial register returns zero. A word or long access in that range fails the mask test. The address 0x05000000 itself is a memory address.
- R9: A byte write to 0x05FFFECB loads the transmit register and raises tx_valid_o from the next cycle until a cycle with tx_ready_i high. The byte 0x0D is dropped. A write made while tx_valid_o is high is dropped.
- R10: A cycle with rx_valid_i high captures rx_data_i and marks the receive register full. A byte read of 0x05FFFECD returns the captured byte and marks the register empty.
- R11: A byte read of 0x05FFFECC returns the status byte. Bit 7 is set when the transmit register is empty, bit 6 is set when the receive register is full, and the other bits are zero.
- R12: After reset, rvalid_o, err_o, rdata_o and tx_valid_o are low, the transmit register is empty and the receive register is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| big_endian_i | input | 1 | Lane order select, high for big-endian |
| req_i | input | 1 | Access request |
| we_i | input | 1 | High for write |
| size_i | input | 2 | 0 byte, 1 word, 2 long, 3 invalid |
| signed_i | input | 1 | Sign-extend byte and word reads |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Write data, right-aligned |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read response strobe |
| err_o | output | 1 | Bus error strobe |
| tx_valid_o | output | 1 | Transmit byte pending |
| tx_data_o | output | 8 | Transmit byte |
| tx_ready_i | input | 1 | Transmit byte taken |
| rx_valid_i | input | 1 | Receive byte strobe |
| rx_data_i | input | 8 | Receive byte |

## Verification
Some properties are checked on every cycle. The response timing of reads and writes is checked. An error must force zero read data. A RAM write must never fire for an address above the memory size, and I/O accesses must never enable the RAM. A held transmit byte must stay stable and must never be a carriage return, and a read of the receive register must mark it empty.

Other behaviour can only be shown by the bench scenarios. These cover the actual lane placement in each endian mode, extension of the read data, aliasing at the top of memory, the boundary address of the I/O window and the status byte values.

// File: rtl/mem_port_pkg.sv
package mem_port_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  localparam logic [31:0] IO_FLOOR  = 32'h0500_0000;
  localparam logic [31:0] TX_ADDR   = 32'h05FF_FECB;
  localparam logic [31:0] STAT_ADDR = 32'h05FF_FECC;
  localparam logic [31:0] RX_ADDR   = 32'h05FF_FECD;
  localparam logic [7:0]  CHAR_CR   = 8'h0D;
endpackage

// File: rtl/mem_port_decode.sv
module mem_port_decode
  import mem_port_pkg::*;
#(
  parameter int ADDR_BITS = 8,
  localparam int IDX_W = ADDR_BITS - 2
) (
  input  logic             req_i,
  input  logic             we_i,
  input  logic [1:0]       size_i,
  input  logic [31:0]      addr_i,
  input  logic [31:0]      wdata_i,
  input  logic             big_endian_i,
  output logic             err_o,
  output logic             io_o,
  output logic             ram_en_o,
  output logic             ram_we_o,
  output logic [3:0]       be_o,
  output logic [31:0]      wlane_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [31:0] MASK_B = 32'((64'd1 << ADDR_BITS) - 64'd1);
  localparam logic [31:0] MASK_W = MASK_B & ~32'd1;
  localparam logic [31:0] MASK_L = MASK_B & ~32'd3;

  acc_size_e   sz;
  logic [31:0] sel_mask;
  logic [1:0]  off;
  logic [1:0]  lo;
  logic [7:0]  first_b, second_b;

  assign sz    = acc_size_e'(size_i);
  assign off   = addr_i[1:0];
  assign lo    = {addr_i[1], 1'b0};
  assign idx_o = addr_i[ADDR_BITS-1:2];

  always_comb begin
    case (sz)
      SZ_BYTE: sel_mask = MASK_B;
      SZ_WORD: sel_mask = MASK_W;
      SZ_LONG: sel_mask = MASK_L;
      default: sel_mask = '0;
    endcase
  end

  // I/O window only for byte accesses strictly above the floor
  assign io_o     = (sz == SZ_BYTE) && (addr_i > IO_FLOOR);
  assign err_o    = !io_o && ((sz == SZ_BAD) || |(addr_i & ~sel_mask));
  assign ram_en_o = req_i && !err_o && !io_o;
  assign ram_we_o = ram_en_o && we_i;

  assign first_b  = big_endian_i ? wdata_i[15:8] : wdata_i[7:0];
  assign second_b = big_endian_i ? wdata_i[7:0]  : wdata_i[15:8];

  always_comb begin
    be_o    = '0;
    wlane_o = '0;
    case (sz)
      SZ_BYTE: begin
        be_o[off] = 1'b1;
        wlane_o[{off, 3'b000} +: 8] = wdata_i[7:0];
      end
      SZ_WORD: begin
        be_o[lo]        = 1'b1;
        be_o[lo | 2'd1] = 1'b1;
        wlane_o[{lo, 3'b000} +: 8]          = first_b;
        wlane_o[{lo | 2'd1, 3'b000} +: 8]   = second_b;
      end
      SZ_LONG: begin
        be_o = 4'hF;
        for (int k = 0; k < 4; k++)
          wlane_o[8*k +: 8] = big_endian_i ? wdata_i[8*(3-k) +: 8] : wdata_i[8*k +: 8];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mem_port_ram.sv
module mem_port_ram #(
  parameter int IDX_W = 6,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             en_i,
  input  logic             we_i,
  input  logic [3:0]       be_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o
);
  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [7:0] bank [DEPTH];
    logic [7:0] rd_q;
    always_ff @(posedge clk_i) begin
      if (en_i) begin
        if (we_i && be_i[g]) bank[idx_i] <= wdata_i[8*g +: 8];
        rd_q <= bank[idx_i];
      end
    end
    assign rdata_o[8*g +: 8] = rd_q;
  end
endmodule

// File: rtl/mem_port_serial.sv
module mem_port_serial
  import mem_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tx_wr_i,
  input  logic       rx_rd_i,
  input  logic [7:0] wbyte_i,
  input  logic       tx_ready_i,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  output logic       tx_valid_o,
  output logic [7:0] tx_data_o,
  output logic [7:0] rx_byte_o,
  output logic [7:0] status_o
);
  logic       tx_full_q, rx_full_q;
  logic [7:0] tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_full_q <= 1'b0;
      tx_q      <= '0;
    end else if (tx_full_q && tx_ready_i) begin
      tx_full_q <= 1'b0;
    end else if (!tx_full_q && tx_wr_i && wbyte_i != CHAR_CR) begin
      tx_full_q <= 1'b1;
      tx_q      <= wbyte_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_full_q <= 1'b0;
      rx_q      <= '0;
    end else if (rx_valid_i) begin
      rx_full_q <= 1'b1;
      rx_q      <= rx_data_i;
    end else if (rx_rd_i) begin
      rx_full_q <= 1'b0;
    end
  end

  assign tx_valid_o = tx_full_q;
  assign tx_data_o  = tx_q;
  assign rx_byte_o  = rx_q;
  assign status_o   = {!tx_full_q, rx_full_q, 6'b0};

  a_r9_tx_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));
  a_r9_no_cr_sent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> tx_data_o != CHAR_CR);
  a_r10_rx_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rd_i && !rx_valid_i |=> !status_o[6]);
endmodule

// File: rtl/mem_port.sv
module mem_port
  import mem_port_pkg::*;
#(
  parameter int ADDR_BITS = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        big_endian_i,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [1:0]  size_i,
  input  logic        signed_i,
  input  logic [31:0] addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        rvalid_o,
  output logic        err_o,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  input  logic        tx_ready_i,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i
);
  localparam int IDX_W = ADDR_BITS - 2;

  logic             dec_err, dec_io, ram_en, ram_we;
  logic [3:0]       be;
  logic [31:0]      wlane, raw;
  logic [IDX_W-1:0] idx;
  logic             tx_wr, rx_rd;
  logic [7:0]       rx_byte, status;

  mem_port_decode #(.ADDR_BITS(ADDR_BITS)) u_dec (
    .req_i, .we_i, .size_i, .addr_i, .wdata_i, .big_endian_i,
    .err_o(dec_err), .io_o(dec_io), .ram_en_o(ram_en), .ram_we_o(ram_we),
    .be_o(be), .wlane_o(wlane), .idx_o(idx)
  );

  mem_port_ram #(.IDX_W(IDX_W)) u_ram (
    .clk_i, .en_i(ram_en), .we_i(ram_we), .be_i(be), .idx_i(idx),
    .wdata_i(wlane), .rdata_o(raw)
  );

  assign tx_wr = req_i && dec_io && we_i && (addr_i == TX_ADDR);
  assign rx_rd = req_i && dec_io && !we_i && (addr_i == RX_ADDR);

  mem_port_serial u_ser (
    .clk_i, .rst_ni, .tx_wr_i(tx_wr), .rx_rd_i(rx_rd), .wbyte_i(wdata_i[7:0]),
    .tx_ready_i, .rx_valid_i, .rx_data_i, .tx_valid_o, .tx_data_o,
    .rx_byte_o(rx_byte), .status_o(status)
  );

  // Response stage
  logic       rvalid_q, err_q, sign_q, big_q, io_q;
  acc_size_e  size_q;
  logic [1:0] off_q;
  logic [7:0] io_byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q  <= 1'b0;
      err_q     <= 1'b0;
      sign_q    <= 1'b0;
      big_q     <= 1'b0;
      io_q      <= 1'b0;
      size_q    <= SZ_BYTE;
      off_q     <= '0;
      io_byte_q <= '0;
    end else begin
      rvalid_q <= req_i && !we_i;
      err_q    <= req_i && dec_err;
      if (req_i) begin
        sign_q <= signed_i;
        big_q  <= big_endian_i;
        io_q   <= dec_io;
        size_q <= acc_size_e'(size_i);
        off_q  <= addr_i[1:0];
        if (addr_i == RX_ADDR)        io_byte_q <= rx_byte;
        else if (addr_i == STAT_ADDR) io_byte_q <= status;
        else                          io_byte_q <= '0;
      end
    end
  end

  logic [7:0]  rb;
  logic [15:0] rw;
  logic [31:0] rl, fmt;
  logic [1:0]  lo_q;

  assign lo_q = {off_q[1], 1'b0};
  assign rb   = io_q ? io_byte_q : raw[{off_q, 3'b000} +: 8];
  assign rw   = big_q ? {raw[{lo_q, 3'b000} +: 8], raw[{lo_q | 2'd1, 3'b000} +: 8]}
                      : {raw[{lo_q | 2'd1, 3'b000} +: 8], raw[{lo_q, 3'b000} +: 8]};
  assign rl   = big_q ? {raw[7:0], raw[15:8], raw[23:16], raw[31:24]} : raw;

  always_comb begin
    case (size_q)
      SZ_BYTE: fmt = {{24{sign_q & rb[7]}}, rb};
      SZ_WORD: fmt = {{16{sign_q & rw[15]}}, rw};
      SZ_LONG: fmt = rl;
      default: fmt = '0;
    endcase
  end

  assign rvalid_o = rvalid_q;
  assign err_o    = err_q;
  assign rdata_o  = (rvalid_q && !err_q) ? fmt : '0;

  a_r7_rvalid_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i |=> rvalid_o);
  a_r7_no_rvalid_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i |=> !rvalid_o);
  a_r2_err_zero_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rdata_o == '0);
  a_r1_ram_write_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we |-> addr_i[31:ADDR_BITS] == '0);
  a_r8_io_bypasses_ram: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && dec_io |-> !ram_en);
endmodule

// File: tb/tb_mem_port.sv
module tb_mem_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        big = 1'b0, req = 1'b0, we = 1'b0, sgn = 1'b0;
  logic [1:0]  size = 2'd0;
  logic [31:0] addr = '0, wdata = '0;
  logic [31:0] rdata_o;
  logic        rvalid_o, err_o, tx_valid_o;
  logic [7:0]  tx_data_o;
  logic        tx_ready = 1'b0, rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;

  int tests_run = 0, tests_failed = 0;
  logic [31:0] got_rd;
  logic        got_rv, got_err;

  localparam logic [31:0] TXA = 32'h05FF_FECB, STA = 32'h05FF_FECC, RXA = 32'h05FF_FECD;

  always #5 clk = ~clk;

  mem_port #(.ADDR_BITS(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .big_endian_i(big), .req_i(req), .we_i(we),
    .size_i(size), .signed_i(sgn), .addr_i(addr), .wdata_i(wdata),
    .rdata_o, .rvalid_o, .err_o, .tx_valid_o, .tx_data_o,
    .tx_ready_i(tx_ready), .rx_valid_i(rx_valid), .rx_data_i(rx_data)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [1:0] sz, input logic sg,
                        input logic [31:0] a, input logic [31:0] wd);
    @(negedge clk);
    req = 1'b1; we = w; size = sz; sgn = sg; addr = a; wdata = wd;
    @(negedge clk);
    got_rv = rvalid_o; got_err = err_o; got_rd = rdata_o;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sz, input logic sg, input logic [31:0] a,
                    input string rq, input logic [31:0] exp);
    access(1'b0, sz, sg, a, '0);
    chk(rq, {31'b0, got_rv}, 32'd1);
    chk(rq, {31'b0, got_err}, 32'd0);
    chk(rq, got_rd, exp);
  endtask

  task automatic rd_err(input logic [1:0] sz, input logic [31:0] a, input string rq);
    access(1'b0, sz, 1'b0, a, '0);
    chk(rq, {31'b0, got_err}, 32'd1);
    chk(rq, {31'b0, got_rv}, 32'd1);
    chk(rq, got_rd, 32'd0);
  endtask

  task automatic t_reset;
    chk("R12 rvalid", {31'b0, rvalid_o}, 0);
    chk("R12 err", {31'b0, err_o}, 0);
    chk("R12 rdata", rdata_o, 0);
    chk("R12 tx_valid", {31'b0, tx_valid_o}, 0);
    rd(2'd0, 1'b0, STA, "R12 status empty", 32'h80);
  endtask

  task automatic t_le;
    big = 1'b0;
    access(1'b1, 2'd2, 1'b0, 32'h10, 32'h1122_3344);
    chk("R7 write no rvalid", {31'b0, got_rv}, 0);
    chk("R7 write no err", {31'b0, got_err}, 0);
    rd(2'd0, 1'b0, 32'h10, "R3 byte0", 32'h44);
    rd(2'd0, 1'b0, 32'h11, "R3 byte1", 32'h33);
    rd(2'd0, 1'b0, 32'h12, "R3 byte2", 32'h22);
    rd(2'd0, 1'b0, 32'h13, "R3 byte3", 32'h11);
    rd(2'd2, 1'b0, 32'h10, "R3 long", 32'h1122_3344);
    rd(2'd1, 1'b0, 32'h12, "R3 word hi", 32'h1122);
    rd(2'd1, 1'b0, 32'h10, "R3 word lo", 32'h3344);
  endtask

  task automatic t_be;
    big = 1'b1;
    rd(2'd2, 1'b0, 32'h10, "R4 long view", 32'h4433_2211);
    rd(2'd1, 1'b0, 32'h10, "R4 word view", 32'h4433);
    access(1'b1, 2'd2, 1'b0, 32'h20, 32'hA1B2_C3D4);
    rd(2'd0, 1'b0, 32'h20, "R4 long msb first", 32'hA1);
    rd(2'd0, 1'b0, 32'h23, "R4 long lsb last", 32'hD4);
    access(1'b1, 2'd1, 1'b0, 32'h26, 32'h0000_5566);
    rd(2'd0, 1'b0, 32'h26, "R4 word msb", 32'h55);
    rd(2'd0, 1'b0, 32'h27, "R4 word lsb", 32'h66);
  endtask

  task automatic t_byte_same;
    big = 1'b1;
    access(1'b1, 2'd0, 1'b0, 32'h31, 32'h0000_007E);
    rd(2'd0, 1'b0, 32'h31, "R5 byte big", 32'h7E);
    big = 1'b0;
    rd(2'd0, 1'b0, 32'h31, "R5 byte little", 32'h7E);
  endtask

  task automatic t_ext;
    big = 1'b0;
    access(1'b1, 2'd2, 1'b0, 32'h40, 32'h80F0_8081);
    rd(2'd0, 1'b1, 32'h40, "R6 byte signed", 32'hFFFF_FF81);
    rd(2'd0, 1'b0, 32'h40, "R6 byte unsigned", 32'h0000_0081);
    rd(2'd1, 1'b1, 32'h42, "R6 word signed", 32'hFFFF_80F0);
    rd(2'd1, 1'b0, 32'h42, "R6 word unsigned", 32'h0000_80F0);
    access(1'b1, 2'd2, 1'b0, 32'h44, 32'h0000_7F12);
    rd(2'd1, 1'b1, 32'h44, "R6 word signed positive", 32'h0000_7F12);
    rd(2'd0, 1'b1, 32'h44, "R6 byte signed positive", 32'h0000_0012);
  endtask

  task automatic t_err;
    big = 1'b0;
    rd_err(2'd1, 32'h11, "R1 misaligned word");
    rd_err(2'd2, 32'h12, "R1 misaligned long");
    rd_err(2'd0, 32'h100, "R1 out of range byte");
    rd_err(2'd3, 32'h10, "R2 size code 3");
    access(1'b1, 2'd2, 1'b0, 32'h12, 32'hDEAD_BEEF);
    chk("R1 write misaligned err", {31'b0, got_err}, 1);
    rd(2'd2, 1'b0, 32'h10, "R2 misaligned write dropped", 32'h1122_3344);
    access(1'b1, 2'd0, 1'b0, 32'h110, 32'h0000_00AA);
    chk("R1 write range err", {31'b0, got_err}, 1);
    rd(2'd0, 1'b0, 32'h10, "R2 out of range write dropped", 32'h44);
  endtask

  task automatic t_io;
    big = 1'b0;
    rd(2'd0, 1'b0, 32'h0500_0010, "R8 io unused reads zero", 32'h0);
    rd_err(2'd1, STA, "R8 io word errors");
    rd_err(2'd0, 32'h0500_0000, "R8 window floor is memory");
    access(1'b1, 2'd0, 1'b0, 32'h0500_0010, 32'h0000_0077);
    chk("R8 io write no err", {31'b0, got_err}, 0);
    rd(2'd0, 1'b0, 32'h10, "R8 io write misses ram", 32'h44);
  endtask

  task automatic t_tx;
    tx_ready = 1'b0;
    access(1'b1, 2'd0, 1'b0, TXA, 32'h0000_0041);
    chk("R9 tx valid", {31'b0, tx_valid_o}, 1);
    chk("R9 tx data", {24'b0, tx_data_o}, 32'h41);
    rd(2'd0, 1'b0, STA, "R11 status tx busy", 32'h00);
    access(1'b1, 2'd0, 1'b0, TXA, 32'h0000_0042);
    chk("R9 write while busy dropped", {24'b0, tx_data_o}, 32'h41);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    chk("R9 tx taken", {31'b0, tx_valid_o}, 0);
    access(1'b1, 2'd0, 1'b0, TXA, 32'h0000_000D);
    chk("R9 carriage return dropped", {31'b0, tx_valid_o}, 0);
    rd(2'd0, 1'b0, STA, "R11 status tx empty", 32'h80);
  endtask

  task automatic t_rx;
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'h5A;
    @(negedge clk); rx_valid = 1'b0;
    rd(2'd0, 1'b0, STA, "R11 status rx full", 32'hC0);
    rd(2'd0, 1'b0, RXA, "R10 rx byte", 32'h5A);
    rd(2'd0, 1'b0, STA, "R10 rx cleared", 32'h80);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests_failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_le();
    t_be();
    t_byte_same();
    t_ext();
    t_err();
    t_io();
    t_tx();
    t_rx();
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule